// File: doc/BRIEF.md
# Receiver Sampling-Time and Antenna Diagnostic Unit

This block sits beside the receive path of an inductive reader front-end and turns digitized measurements into calibration and health information. Whenever a fresh antenna phase count is delivered, it records that count for the host. It then derives the demodulator sampling time as the doubled phase plus a programmable offset. The offset covers the delay from tap attenuation and low-pass filtering. The result clips at its largest code. Each update starts a programmable settle interval, and the data-valid output stays low until that interval ends.

The block also tracks the demodulated amplitude. While the acquire control is held high, each amplitude sample is stored as the reference. Once the control drops, a status bit reports whether the present amplitude is strictly larger than that stored reference. A third function watches the receiver-input comparator once per carrier period and raises an antenna-fail flag when the input stays at or below the diagnostic threshold, which points to a shorted or open antenna. That flag has no meaning in idle or power-down mode, before the oscillator is ready, or while the antenna drivers are off. In those states the flag reads 0 and a separate status-valid output is low.

Top module: `rx_sample_diag`

## Requirements
- R1: After reset, samp_time, phase_rpt, data_valid, amp_cmp, ant_fail and stat_valid are all 0.
- R2: On the clock edge where phase_valid is high, phase_rpt takes phase_in and samp_time takes 2*phase_in + offset_in. Both are visible from the following cycle.
- R3: When 2*phase_in + offset_in exceeds 127, samp_time becomes 127.
- R4: Without phase_valid, samp_time and phase_rpt hold their values, even if offset_in or phase_in change.
- R5: An update loads a counter with settle_len. data_valid is high only when at least one update has happened and that counter has reached 0. The counter counts down by one per cycle, so data_valid stays low for settle_len cycles after each update. A new update during the count restarts it.
- R6: On every edge where acq_amp is high, amp_in is stored as the reference and amp_cmp becomes 0. While acq_amp is low, the reference does not change.
- R7: On an edge where acq_amp is low, amp_cmp becomes 1 if amp_in is strictly greater than the stored reference and 0 otherwise, so an equal amplitude gives 0.
- R8: The status is defined when pwr_mode is 2'b00 (active), osc_ready is 1 and drv_en is 1. In that state, on an edge with carrier_tick high, ant_fail becomes the inverse of rx_above_thr and stat_valid becomes 1. Between ticks, ant_fail holds its value.
- R9: On any edge where the status is undefined, ant_fail and stat_valid become 0. Undefined means pwr_mode is 2'b01 (idle), 2'b10 or 2'b11 (power-down), or osc_ready is 0, or drv_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_valid | input | 1 | Strobe for a new phase measurement |
| phase_in | input | PHASE_W | Measured antenna phase in clock ticks |
| offset_in | input | OFFS_W | Programmable sampling offset |
| settle_len | input | SETTLE_W | Settle period in cycles after an update |
| acq_amp | input | 1 | Acquire-reference control |
| amp_in | input | AMP_W | Demodulated amplitude sample |
| carrier_tick | input | 1 | One pulse per carrier period |
| rx_above_thr | input | 1 | Receiver input exceeds the diagnostic threshold |
| pwr_mode | input | 2 | 00 active, 01 idle, 10/11 power-down |
| osc_ready | input | 1 | Oscillator start-up complete |
| drv_en | input | 1 | Antenna drivers enabled |
| samp_time | output | TS_W | Demodulator sampling time |
| phase_rpt | output | PHASE_W | Last measured phase |
| data_valid | output | 1 | Receiver settled after the last update |
| amp_cmp | output | 1 | Amplitude above the stored reference |
| ant_fail | output | 1 | Antenna-fail status |
| stat_valid | output | 1 | Antenna-fail status is defined |

## Verification
The bench uses the default 6-bit phase and offset, the 7-bit sampling time and the 8-bit amplitude. It narrows SETTLE_W to 4 so that every settle length from 0 to 15 is reachable. Random phase and offset values over their full range cross the clipping point often. Directed cases still target sums of exactly 127 and 128 and the largest input pair. The narrow settle counter lets random updates land both inside and after a running settle interval, which exercises the restart. Amplitudes are drawn from a small range so that equal values, which must give 0, come up often.

// File: rtl/rx_diag_pkg.sv
package rx_diag_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_IDLE   = 2'b01,
    PM_DOWN   = 2'b10,
    PM_OFF    = 2'b11
  } pwr_mode_e;
endpackage

// File: rtl/rx_samp_calc.sv
module rx_samp_calc #(
  parameter int PHASE_W  = 6,
  parameter int OFFS_W   = 6,
  parameter int TS_W     = 7,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                phase_valid,
  input  logic [PHASE_W-1:0]  phase_in,
  input  logic [OFFS_W-1:0]   offset_in,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic [TS_W-1:0]     samp_time,
  output logic [PHASE_W-1:0]  phase_rpt,
  output logic                data_valid
);
  localparam int SUM_W  = ((PHASE_W + 1 > OFFS_W) ? PHASE_W + 1 : OFFS_W) + 1;
  localparam int TS_MAX = (1 << TS_W) - 1;

  logic [SUM_W-1:0]    sum;
  logic [TS_W-1:0]     ts_d, ts_q;
  logic [PHASE_W-1:0]  ph_q;
  logic [SETTLE_W-1:0] cnt_d, cnt_q;
  logic                set_d, set_q;

  always_comb begin
    sum = SUM_W'({phase_in, 1'b0}) + SUM_W'(offset_in);
    if (32'(sum) > TS_MAX) ts_d = TS_W'(TS_MAX);
    else                   ts_d = TS_W'(sum);
    set_d = set_q | phase_valid;
    if (phase_valid)       cnt_d = settle_len;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q  <= '0;
      ph_q  <= '0;
      cnt_q <= '0;
      set_q <= 1'b0;
    end else begin
      if (phase_valid) begin
        ts_q <= ts_d;
        ph_q <= phase_in;
      end
      cnt_q <= cnt_d;
      set_q <= set_d;
    end
  end

  assign samp_time  = ts_q;
  assign phase_rpt  = ph_q;
  assign data_valid = set_q && (cnt_q == '0);

  AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !phase_valid |=> $stable(samp_time) && $stable(phase_rpt)); // R4
  AST_TS_FLOOR: assert property (@(posedge clk) disable iff (!rst_ni)
    phase_valid |=> (32'(samp_time) >= 32'($past(offset_in)))); // R2
  AST_TS_CEIL: assert property (@(posedge clk) disable iff (!rst_ni)
    phase_valid |=> (32'(samp_time) >= 32'($past(phase_in)) || samp_time == TS_W'(TS_MAX))); // R3
  AST_SETTLE_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_valid && settle_len != '0) |=> !data_valid); // R5
endmodule

// File: rtl/rx_amp_track.sv
module rx_amp_track #(
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             acq_amp,
  input  logic [AMP_W-1:0] amp_in,
  output logic             amp_cmp
);
  logic [AMP_W-1:0] ref_q;
  logic             cmp_d, cmp_q;

  always_comb begin
    if (acq_amp) cmp_d = 1'b0;
    else         cmp_d = (amp_in > ref_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      cmp_q <= 1'b0;
    end else begin
      if (acq_amp) ref_q <= amp_in;
      cmp_q <= cmp_d;
    end
  end

  assign amp_cmp = cmp_q;

  AST_ACQ_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    acq_amp |=> !amp_cmp); // R6
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !acq_amp |=> $stable(ref_q)); // R6
  AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_ni)
    (acq_amp ##1 (!acq_amp && amp_in == $past(amp_in))) |=> !amp_cmp); // R7
endmodule

// File: rtl/rx_ant_monitor.sv
module rx_ant_monitor
  import rx_diag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       carrier_tick,
  input  logic       rx_above_thr,
  input  logic [1:0] pwr_mode,
  input  logic       osc_ready,
  input  logic       drv_en,
  output logic       ant_fail,
  output logic       stat_valid
);
  pwr_mode_e mode;
  logic      undef;
  logic      fail_d, fail_q, vld_d, vld_q;

  always_comb begin
    mode   = pwr_mode_e'(pwr_mode);
    undef  = (mode != PM_ACTIVE) || !osc_ready || !drv_en;
    fail_d = fail_q;
    vld_d  = vld_q;
    if (undef) begin
      fail_d = 1'b0;
      vld_d  = 1'b0;
    end else if (carrier_tick) begin
      fail_d = !rx_above_thr;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      fail_q <= fail_d;
      vld_q  <= vld_d;
    end
  end

  assign ant_fail   = fail_q;
  assign stat_valid = vld_q;

  AST_UNDEF_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    undef |=> (!ant_fail && !stat_valid)); // R9
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!undef && !carrier_tick) |=> $stable(ant_fail)); // R8
  AST_TICK_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
    (!undef && carrier_tick) |=> stat_valid); // R8
endmodule

// File: rtl/rx_sample_diag.sv
module rx_sample_diag #(
  parameter int PHASE_W  = 6,
  parameter int OFFS_W   = 6,
  parameter int TS_W     = 7,
  parameter int SETTLE_W = 8,
  parameter int AMP_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                phase_valid,
  input  logic [PHASE_W-1:0]  phase_in,
  input  logic [OFFS_W-1:0]   offset_in,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                acq_amp,
  input  logic [AMP_W-1:0]    amp_in,
  input  logic                carrier_tick,
  input  logic                rx_above_thr,
  input  logic [1:0]          pwr_mode,
  input  logic                osc_ready,
  input  logic                drv_en,
  output logic [TS_W-1:0]     samp_time,
  output logic [PHASE_W-1:0]  phase_rpt,
  output logic                data_valid,
  output logic                amp_cmp,
  output logic                ant_fail,
  output logic                stat_valid
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rx_samp_calc #(
    .PHASE_W(PHASE_W), .OFFS_W(OFFS_W), .TS_W(TS_W), .SETTLE_W(SETTLE_W)
  ) u_calc (
    .clk(clk), .rst_ni(rst_ni), .phase_valid(phase_valid),
    .phase_in(phase_in), .offset_in(offset_in), .settle_len(settle_len),
    .samp_time(samp_time), .phase_rpt(phase_rpt), .data_valid(data_valid)
  );

  rx_amp_track #(.AMP_W(AMP_W)) u_amp (
    .clk(clk), .rst_ni(rst_ni), .acq_amp(acq_amp), .amp_in(amp_in),
    .amp_cmp(amp_cmp)
  );

  rx_ant_monitor u_ant (
    .clk(clk), .rst_ni(rst_ni), .carrier_tick(carrier_tick),
    .rx_above_thr(rx_above_thr), .pwr_mode(pwr_mode),
    .osc_ready(osc_ready), .drv_en(drv_en),
    .ant_fail(ant_fail), .stat_valid(stat_valid)
  );
endmodule

// File: tb/rx_sample_diag_bench.sv
module rx_sample_diag_bench;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_valid = 1'b0;
  logic [5:0] phase_in = '0;
  logic [5:0] offset_in = '0;
  logic [SW-1:0] settle_len = '0;
  logic acq_amp = 1'b0;
  logic [7:0] amp_in = '0;
  logic carrier_tick = 1'b0;
  logic rx_above_thr = 1'b0;
  logic [1:0] pwr_mode = 2'b00;
  logic osc_ready = 1'b1;
  logic drv_en = 1'b1;
  logic [6:0] samp_time;
  logic [5:0] phase_rpt;
  logic data_valid, amp_cmp, ant_fail, stat_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  int m_ts = 0, m_ph = 0, m_cnt = 0, m_ref = 0;
  bit m_set = 0, m_cmp = 0, m_fail = 0, m_vld = 0;

  always #2.5 clk = ~clk;

  rx_sample_diag #(.SETTLE_W(SW)) u_rx_sample_diag (
    .clk(clk), .rst_n(rst_n), .phase_valid(phase_valid), .phase_in(phase_in),
    .offset_in(offset_in), .settle_len(settle_len), .acq_amp(acq_amp),
    .amp_in(amp_in), .carrier_tick(carrier_tick), .rx_above_thr(rx_above_thr),
    .pwr_mode(pwr_mode), .osc_ready(osc_ready), .drv_en(drv_en),
    .samp_time(samp_time), .phase_rpt(phase_rpt), .data_valid(data_valid),
    .amp_cmp(amp_cmp), .ant_fail(ant_fail), .stat_valid(stat_valid)
  );

  function automatic int exp_ts(int ph, int off);
    int s = 2 * ph + off;
    return (s > 127) ? 127 : s;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2/R4 samp_time"}, samp_time, m_ts);
    chk({tag, " R2 phase_rpt"}, phase_rpt, m_ph);
    chk({tag, " R5 data_valid"}, data_valid, int'(m_set && m_cnt == 0));
    chk({tag, " R7 amp_cmp"}, amp_cmp, m_cmp);
    chk({tag, " R8 ant_fail"}, ant_fail, m_fail);
    chk({tag, " R9 stat_valid"}, stat_valid, m_vld);
  endtask

  // drive one cycle, update model at the edge, sample after it
  task automatic step(bit pv, int ph, int off, int sl, bit acq, int amp,
                      bit tick, bit above, int mode, bit osc, bit drv);
    bit und;
    @(negedge clk);
    phase_valid = pv; phase_in = 6'(ph); offset_in = 6'(off);
    settle_len = SW'(sl); acq_amp = acq; amp_in = 8'(amp);
    carrier_tick = tick; rx_above_thr = above; pwr_mode = 2'(mode);
    osc_ready = osc; drv_en = drv;
    @(posedge clk);
    if (pv) begin
      m_ts = exp_ts(ph, off); m_ph = ph; m_cnt = sl; m_set = 1;
    end else if (m_cnt > 0) m_cnt--;
    if (acq) begin m_ref = amp; m_cmp = 0; end
    else m_cmp = (amp > m_ref);
    und = (mode != 0) || !osc || !drv;
    if (und) begin m_fail = 0; m_vld = 0; end
    else if (tick) begin m_fail = !above; m_vld = 1; end
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 samp_time", samp_time, 0);
    chk("R1 phase_rpt", phase_rpt, 0);
    chk("R1 data_valid", data_valid, 0);
    chk("R1 amp_cmp", amp_cmp, 0);
    chk("R1 ant_fail", ant_fail, 0);
    chk("R1 stat_valid", stat_valid, 0);

    // R2 basic, R5 settle of 3 cycles
    step(1, 20, 5, 3, 0, 0, 0, 1, 0, 1, 1); check_all("R2 dir");
    chk("R5 low after update", data_valid, 0);
    step(0, 50, 60, 0, 0, 0, 0, 1, 0, 1, 1); check_all("R4 hold");
    step(0, 1, 1, 0, 0, 0, 0, 1, 0, 1, 1); check_all("R5 cnt1");
    step(0, 1, 1, 0, 0, 0, 0, 1, 0, 1, 1); check_all("R5 cnt0");
    chk("R5 high after settle", data_valid, 1);
    // R3 saturation corners
    step(1, 32, 63, 0, 0, 0, 0, 1, 0, 1, 1); chk("R3 exact 127", samp_time, 127);
    step(1, 33, 62, 0, 0, 0, 0, 1, 0, 1, 1); chk("R3 128 clips", samp_time, 127);
    step(1, 63, 63, 0, 0, 0, 0, 1, 0, 1, 1); chk("R3 max inputs", samp_time, 127);
    chk("R5 zero settle", data_valid, 1);
    // R5 restart during settle
    step(1, 4, 0, 5, 0, 0, 0, 1, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1);
    step(1, 5, 0, 2, 0, 0, 0, 1, 0, 1, 1); check_all("R5 restart");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1); chk("R5 restart low", data_valid, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1); chk("R5 restart high", data_valid, 1);
    // R6/R7 capture then compare, equal gives 0
    step(0, 0, 0, 0, 1, 100, 0, 1, 0, 1, 1); chk("R6 acq zero", amp_cmp, 0);
    step(0, 0, 0, 0, 0, 100, 0, 1, 0, 1, 1); chk("R7 equal", amp_cmp, 0);
    step(0, 0, 0, 0, 0, 101, 0, 1, 0, 1, 1); chk("R7 above", amp_cmp, 1);
    step(0, 0, 0, 0, 0, 99, 0, 1, 0, 1, 1);  chk("R7 below", amp_cmp, 0);
    // R8/R9 antenna status
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 1); chk("R8 fail", ant_fail, 1);
    chk("R8 valid", stat_valid, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1); chk("R8 hold", ant_fail, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 1); chk("R9 idle fail", ant_fail, 0);
    chk("R9 idle valid", stat_valid, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0); chk("R9 drv off", stat_valid, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1); chk("R9 osc off", ant_fail, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 1); chk("R8 pass", ant_fail, 0);
    chk("R8 pass valid", stat_valid, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int md;
      md = ($urandom % 8 == 0) ? int'($urandom % 4) : 0;
      step(($urandom % 5) == 0, $urandom % 64, $urandom % 64, $urandom % 16,
           ($urandom % 8) == 0, $urandom % 6, ($urandom % 4) == 0,
           ($urandom % 2) == 0, md, ($urandom % 16) != 0, ($urandom % 16) != 0);
      check_all("rand");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule